// File: doc/BRIEF.md
# Guard Channel Qualifier

This block sits on the receive side of a protection signalling terminal. It accepts a guard command from the demodulator and drives the guard outputs. A guard level is accepted only after it has stayed high without a break for a programmable pickup time. The accepted guard is then stretched for a programmable hold time, so that short dropouts or noise bursts do not release the guard relays. A configuration input bypasses the stretch.

A held trip from the trip path cancels the stretched guard at once. An active hard-block alarm gates the outputs off for as long as it lasts. A power-fail condition, meaning both supply monitors are low, also gates them off, and that gate is extended by a fixed interval after the supply recovers. When the guard is valid, the block drives three outputs: a steady level for an electromechanical relay, a square wave for a solid-state relay, and a steady indicator. All timing runs on a tick of one millisecond, divided down from the system clock. The guard input and both supply monitors pass through a synchronizer before any timer logic uses them.

Top module: `guard_qualifier_top`

## Requirements
- R1: In reset, all outputs are low. After reset, the outputs stay blocked for the power-fail extension interval of PF_EXT_TICKS ticks, and become free within that interval plus a few cycles.
- R2: With a pickup setting of P ticks, the relay output rises no earlier than 3+(P-1)·CLK_PER_TICK clocks and no later than 3+P·CLK_PER_TICK clocks after the guard input rises. With P=0 it rises exactly 3 clocks after the guard input rises.
- R3: A low on the guard input lasting even one clock restarts the pickup count from zero.
- R4: With the hold enabled and a hold setting of H ticks (H≥1), the relay output stays high for at least 3+(H-1)·CLK_PER_TICK clocks after the guard input falls, and falls by 3+H·CLK_PER_TICK clocks.
- R5: With the hold disabled, or with H=0, the relay output falls exactly 3 clocks after the guard input falls.
- R6: A held-trip input forces the relay output low on the next clock and discards any remaining hold time. After the trip is released, the output does not return unless the guard is present again.
- R7: While the alarm is high, the outputs are low from the next clock onward. They return on the clock after the alarm falls if the guard is still valid.
- R8: When both power-fail inputs are low, the outputs are blocked 3 clocks later. After either input returns high, the block persists for between 3+(PF_EXT_TICKS-1)·CLK_PER_TICK and 3+PF_EXT_TICKS·CLK_PER_TICK clocks. A single low power-fail input has no effect.
- R9: The solid-state output is high on the first active clock and toggles every SQW_HALF clocks, giving a period of 2·SQW_HALF clocks at 50% duty. It is low whenever the relay output is low.
- R10: The indicator output equals the relay output on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_in | input | 1 | Received guard command level |
| trip_held | input | 1 | Held-trip status from the trip path |
| alarm | input | 1 | Hard-block alarm |
| pwr_mon_a_n | input | 1 | First supply monitor, low on under-voltage |
| pwr_mon_b_n | input | 1 | Second supply monitor, low on under-voltage |
| pickup_ticks | input | 16 | Pickup interval in ticks |
| hold_ticks | input | 16 | Hold interval in ticks |
| hold_en | input | 1 | Enables the hold stretch |
| relay_out | output | 1 | Electromechanical relay drive |
| ssr_out | output | 1 | Solid-state relay square-wave drive |
| ind_out | output | 1 | Guard indicator |

## Verification
Internal state that goes wrong shows up mostly as a shift in the edge times of relay_out. If the pickup counter is not cleared, the relay rises a whole tick or more too early after a glitch. If the hold counter is not abandoned, the relay comes back after a trip is released. If the extension counter is mis-armed, the relay frees too early after reset or after a power failure. Each of these appears within one tick period of the event. A broken square-wave divider shows within one half-period of activation, and the bench checks the solid-state output on every clock of two full periods.

// File: rtl/gq_pkg.sv
package gq_pkg;
   parameter int unsigned GQ_TIME_W = 16;
   typedef logic [GQ_TIME_W-1:0] gq_time_t;
endpackage

// File: rtl/gq_sync.sv
module gq_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("gq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gq_tick.sv
module gq_tick #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad
      $error("gq_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV-1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);

      tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST);
   end
endmodule

// File: rtl/gq_pickup.sv
module gq_pickup
   import gq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     lvl,
   input  gq_time_t limit,
   output logic     ok
);
   gq_time_t cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!lvl) cnt <= '0;
      else if (tick && (cnt != '1)) cnt <= cnt + 1'b1;
   end

   assign ok = lvl && (cnt >= limit);

   // R3
   pickup_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $past(lvl));
endmodule

// File: rtl/gq_hold.sv
module gq_hold
   import gq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     in,
   input  logic     trip,
   input  logic     en,
   input  gq_time_t limit,
   output logic     out
);
   gq_time_t cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (trip) cnt <= '0;
      else if (in) cnt <= limit;
      else if (tick && (cnt != '0)) cnt <= cnt - 1'b1;
   end

   assign out = !trip && (in || (en && (cnt != '0)));

   // R6
   trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> (cnt == '0));
endmodule

// File: rtl/gq_pfblock.sv
module gq_pfblock #(
   parameter int unsigned EXT_TICKS = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pf_low,
   output logic block
);
   localparam int unsigned CW = $clog2(EXT_TICKS + 1);
   localparam logic [CW-1:0] EXT = CW'(EXT_TICKS);

   if (EXT_TICKS < 1) begin : g_bad
      $error("gq_pfblock: EXT_TICKS must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= EXT;
      else if (pf_low) cnt <= EXT;
      else if (tick && (cnt != '0)) cnt <= cnt - 1'b1;
   end

   assign block = pf_low || (cnt != '0);

   // R8
   pf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_low |=> (cnt == EXT));
endmodule

// File: rtl/gq_sqwave.sv
module gq_sqwave #(
   parameter int unsigned HALF = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sq
);
   if (HALF < 2) begin : g_bad
      $error("gq_sqwave: HALF must be at least 2");
   end

   localparam int unsigned CW = $clog2(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF-1);

   logic [CW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; run <= 1'b0; sq <= 1'b0;
      end else if (!en) begin
         cnt <= '0; run <= 1'b0; sq <= 1'b0;
      end else if (!run) begin
         cnt <= '0; run <= 1'b1; sq <= 1'b1;
      end else if (cnt == LAST) begin
         cnt <= '0; sq <= ~sq;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   sq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sq);
   // R9
   sq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/guard_qualifier_top.sv
module guard_qualifier_top
   import gq_pkg::*;
#(
   parameter int unsigned CLK_PER_TICK = 32768,
   parameter int unsigned PF_EXT_TICKS = 600,
   parameter int unsigned SQW_HALF     = 512,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        guard_in,
   input  logic        trip_held,
   input  logic        alarm,
   input  logic        pwr_mon_a_n,
   input  logic        pwr_mon_b_n,
   input  logic [15:0] pickup_ticks,
   input  logic [15:0] hold_ticks,
   input  logic        hold_en,
   output logic        relay_out,
   output logic        ssr_out,
   output logic        ind_out
);
   if (GQ_TIME_W != 16) begin : g_bad_w
      $error("guard_qualifier_top: timer width must match the 16-bit ports");
   end

   logic [2:0] raw_s;
   logic       guard_s, pf_low, tick, pg_ok, held, pf_blk, active;
   logic       relay_q;

   gq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d({guard_in, pwr_mon_a_n, pwr_mon_b_n}), .q(raw_s));

   assign guard_s = raw_s[2];
   assign pf_low  = !raw_s[1] && !raw_s[0];

   gq_tick #(.DIV(CLK_PER_TICK)) tick_i (.clk(clk), .rst_n(rst_n), .tick(tick));

   gq_pickup pickup_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(guard_s),
      .limit(gq_time_t'(pickup_ticks)), .ok(pg_ok));

   gq_hold hold_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .in(pg_ok), .trip(trip_held),
      .en(hold_en), .limit(gq_time_t'(hold_ticks)), .out(held));

   gq_pfblock #(.EXT_TICKS(PF_EXT_TICKS)) pf_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pf_low(pf_low), .block(pf_blk));

   assign active = held && !alarm && !pf_blk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) relay_q <= 1'b0;
      else relay_q <= active;
   end

   gq_sqwave #(.HALF(SQW_HALF)) sq_i (
      .clk(clk), .rst_n(rst_n), .en(active), .sq(ssr_out));

   assign relay_out = relay_q;
   assign ind_out   = relay_q;

   // R6
   trip_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_held |=> !relay_out);
   // R7
   alarm_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |=> !relay_out);
   // R8
   pf_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_low |=> !relay_out);
   // R9
   ssr_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ssr_out |-> relay_out);
   // R10
   ind_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ind_out == relay_out);
endmodule

// File: tb/guard_qualifier_top_tb_top.sv
module guard_qualifier_top_tb_top;
   localparam int T  = 4;
   localparam int E  = 5;
   localparam int HS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic guard_in = 1'b0, trip_held = 1'b0, alarm = 1'b0;
   logic pwr_mon_a_n = 1'b1, pwr_mon_b_n = 1'b1, hold_en = 1'b0;
   logic [15:0] pickup_ticks = '0, hold_ticks = '0;
   logic relay_out, ssr_out, ind_out;
   int vectors = 0, miscompares = 0;

   always #2 clk = ~clk;

   guard_qualifier_top #(.CLK_PER_TICK(T), .PF_EXT_TICKS(E), .SQW_HALF(HS)) dut_i (
      .clk(clk), .rst_n(rst_n), .guard_in(guard_in), .trip_held(trip_held),
      .alarm(alarm), .pwr_mon_a_n(pwr_mon_a_n), .pwr_mon_b_n(pwr_mon_b_n),
      .pickup_ticks(pickup_ticks), .hold_ticks(hold_ticks), .hold_en(hold_en),
      .relay_out(relay_out), .ssr_out(ssr_out), .ind_out(ind_out));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
      vectors++;
      if (ind_out !== relay_out) begin
         miscompares++;
         $display("FAIL R10 actual=%0b expected=%0b", ind_out, relay_out);
      end
   endtask

   task automatic drop_guard();
      guard_in = 1'b0; hold_en = 1'b0;
      step(12);
   endtask

   task automatic pickup_case(input int p);
      pickup_ticks = 16'(p);
      drop_guard();
      chk("R2 idle", relay_out, 1'b0);
      guard_in = 1'b1;
      if (p == 0) begin
         step(2); chk("R2 early", relay_out, 1'b0);
         step(1); chk("R2 late", relay_out, 1'b1);
      end else begin
         step(3 + (p-1)*T); chk("R2 early", relay_out, 1'b0);
         step(T);           chk("R2 late", relay_out, 1'b1);
      end
   endtask

   task automatic hold_case(input int h);
      drop_guard();
      pickup_ticks = 16'd1; hold_ticks = 16'(h); hold_en = 1'b1;
      guard_in = 1'b1;
      step(3 + T); chk("R4 on", relay_out, 1'b1);
      guard_in = 1'b0;
      if (h == 0) begin
         step(2); chk("R5 h0 before", relay_out, 1'b1);
         step(1); chk("R5 h0 after", relay_out, 1'b0);
      end else begin
         step(3 + (h-1)*T); chk("R4 held", relay_out, 1'b1);
         step(T);           chk("R4 released", relay_out, 1'b0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      guard_in = 1'b1;
      step(3);
      chk("R1 reset relay", relay_out, 1'b0);
      chk("R1 reset ssr", ssr_out, 1'b0);
      rst_n = 1'b1;
      step((E-1)*T); chk("R1 ext block", relay_out, 1'b0);
      step(T + 8);   chk("R1 ext free", relay_out, 1'b1);

      for (int p = 0; p <= 5; p++) pickup_case(p);

      // R3: a one-clock glitch restarts the pickup
      pickup_ticks = 16'd4;
      drop_guard();
      guard_in = 1'b1;
      step(3*T);
      guard_in = 1'b0; step(1); guard_in = 1'b1;
      step(3 + 3*T); chk("R3 restart early", relay_out, 1'b0);
      step(T);       chk("R3 restart late", relay_out, 1'b1);

      for (int h = 0; h <= 4; h++) hold_case(h);

      // R5: hold disabled falls at once
      drop_guard();
      pickup_ticks = 16'd0; hold_ticks = 16'd4; hold_en = 1'b0;
      guard_in = 1'b1; step(4); chk("R5 on", relay_out, 1'b1);
      guard_in = 1'b0;
      step(2); chk("R5 before", relay_out, 1'b1);
      step(1); chk("R5 after", relay_out, 1'b0);

      // R6: trip cancels the hold
      drop_guard();
      pickup_ticks = 16'd1; hold_ticks = 16'd5; hold_en = 1'b1;
      guard_in = 1'b1; step(3 + T); chk("R6 on", relay_out, 1'b1);
      guard_in = 1'b0; step(3 + T); chk("R6 in hold", relay_out, 1'b1);
      trip_held = 1'b1; step(1); chk("R6 trip", relay_out, 1'b0);
      trip_held = 1'b0; step(1); chk("R6 abandoned", relay_out, 1'b0);
      step(2*T);      chk("R6 stays low", relay_out, 1'b0);

      // R7 and R9: alarm block, then the square wave on release
      drop_guard();
      pickup_ticks = 16'd0;
      guard_in = 1'b1; step(6); chk("R7 on", relay_out, 1'b1);
      alarm = 1'b1; step(1);
      chk("R7 blocked", relay_out, 1'b0);
      chk("R9 ssr off", ssr_out, 1'b0);
      step(5); chk("R7 still blocked", relay_out, 1'b0);
      alarm = 1'b0; step(1);
      chk("R7 restored", relay_out, 1'b1);
      chk("R9 ssr first", ssr_out, 1'b1);
      for (int n = 1; n < 4*HS; n++) begin
         step(1);
         chk("R9 ssr wave", ssr_out, ((n / HS) % 2) == 0);
      end

      // R8: one monitor low has no effect
      pwr_mon_a_n = 1'b0; step(10);
      chk("R8 single low", relay_out, 1'b1);
      pwr_mon_a_n = 1'b1; step(3);
      // R8: both low, then the extension
      pwr_mon_a_n = 1'b0; pwr_mon_b_n = 1'b0;
      step(2); chk("R8 before block", relay_out, 1'b1);
      step(1); chk("R8 blocked", relay_out, 1'b0);
      chk("R9 ssr blocked", ssr_out, 1'b0);
      step(7);
      pwr_mon_a_n = 1'b1; pwr_mon_b_n = 1'b1;
      step(3 + (E-1)*T); chk("R8 extension", relay_out, 1'b0);
      step(T);           chk("R8 free", relay_out, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule